// File: doc/BRIEF.md
# RTC Interrupt and Watchdog Controller

This block is the interrupt and watchdog section of a memory-mapped real-time-clock device. It sits on a simple synchronous bus and holds three byte-wide registers: a read-only status register with two event flags, a two-bit alarm routing register and a watchdog configuration register. A watchdog down-counter runs on a prescaler tick. Software keeps it from expiring by writing a nonzero value to the watchdog register, which reloads it, and disables it by writing zero.

The alarm comparison, the prescaler tick, the frequency-test request with its square wave, and the supply-loss indication all come from elsewhere in the device. The block merges the alarm and watchdog events onto one shared open-drain line, which is modelled as an active-low pull-down enable. On that line, either interrupt source takes priority over the frequency-test waveform. A watchdog that is not routed to the shared line instead produces a one-clock reset request on a separate output.

Top module: `rtc_irq_wdog`

## Requirements
- R1: After reset, all three registers read 0x00, `irq_oe_n` is 1 and `wd_rst_req_o` is 0.
- R2: The status register is at address 0 and is read-only. Bit 7 is the watchdog flag, bit 6 is the alarm flag, and all other bits read 0. The alarm routing register is at address 6. Bit 7 routes the alarm to the line and bit 6 keeps it routed during supply loss; all other bits read 0. The watchdog register is at address 7 and reads back as written. Its bit 7 is the steering bit, bits 6:5 are the resolution and bits 4:0 are the count. Every other address reads 0x00.
- R3: A pulse on `alarm_hit_i` sets the alarm flag at that clock edge, whatever the routing bits are.
- R4: The alarm flag is cleared only by a read of address 0 that is held for two consecutive cycles. The clear happens at the edge that ends the second cycle. A one-cycle read leaves the flag set. If an alarm pulse arrives in the clearing cycle, the flag stays set.
- R5: `irq_oe_n` is 0 whenever the alarm flag is set and alarm routing is on, provided that either `power_down_i` is low or the supply-loss routing bit is set.
- R6: A nonzero write to the watchdog register arms the counter and restarts it. The timeout occurs on the (max(count,1) × 4^resolution)-th tick after the write, so one unit is 1, 4, 16 or 64 ticks.
- R7: A timeout sets the watchdog flag. With the steering bit set, it also pulls `irq_oe_n` low, and the line stays low until 0x00 is written to the watchdog register. Reading the status register does not release it.
- R8: With the steering bit clear, a timeout drives `wd_rst_req_o` high for exactly one clock and does not pull the shared line low.
- R9: Writing 0x00 to the watchdog register stops the counter and clears the watchdog flag and any pending watchdog interrupt.
- R10: While `power_down_i` is high, the watchdog register is held at zero, the counter is stopped and the watchdog flag and pending interrupt are cleared. Writes to the watchdog register have no effect during that time.
- R11: When neither interrupt is pending, `irq_oe_n` follows `ft_wave_i` only if `freq_test_i` is high and both the alarm routing bit and the watchdog steering bit are clear. Otherwise `irq_oe_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe, level per cycle |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the addressed register |
| tick_i | input | 1 | Prescaler tick, one-cycle pulse |
| alarm_hit_i | input | 1 | Alarm comparison match pulse |
| freq_test_i | input | 1 | Frequency-test request |
| ft_wave_i | input | 1 | Frequency-test square wave |
| power_down_i | input | 1 | Supply-loss indication |
| irq_oe_n | output | 1 | Shared line pull-down enable, 0 pulls low |
| wd_rst_req_o | output | 1 | One-clock watchdog reset request |

## Verification
The properties take for granted that `alarm_hit_i`, `tick_i` and the bus strobes are synchronous to `clk` and settle before the edge. They also assume that `power_down_i` acts as a level that overrides every watchdog write. The stimulus changes every input only at the falling edge. It keeps `tick_i` pulses a single cycle wide, and it uses watchdog counts and resolutions that the bench can reach, so every timeout lands on a tick that the bench itself counted.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    localparam int DATA_W = 8;
    localparam int CNT_W  = 5;
    localparam int RES_W  = 2;
    localparam int SUB_W  = 2 * ((1 << RES_W) - 1);

    localparam int WDF_BIT = 7;
    localparam int AF_BIT  = 6;
    localparam int AEN_BIT = 7;
    localparam int ABE_BIT = 6;

    typedef struct packed {
        logic             steer;
        logic [RES_W-1:0] res;
        logic [CNT_W-1:0] count;
    } wd_cfg_t;

    typedef struct packed {
        logic pin_en;
        logic batt_en;
    } alm_cfg_t;

    typedef struct packed {
        logic wdf;
        logic af;
    } flag_t;

    function automatic logic [SUB_W-1:0] last_sub(input logic [RES_W-1:0] res);
        logic [SUB_W:0] p;
        logic [SUB_W:0] m;
        p = {{SUB_W{1'b0}}, 1'b1};
        p = p << {res, 1'b0};
        m = p - {{SUB_W{1'b0}}, 1'b1};
        return m[SUB_W-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] pack_flags(input flag_t f);
        logic [DATA_W-1:0] r;
        r = '0;
        r[WDF_BIT] = f.wdf;
        r[AF_BIT]  = f.af;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pack_alm(input alm_cfg_t a);
        logic [DATA_W-1:0] r;
        r = '0;
        r[AEN_BIT] = a.pin_en;
        r[ABE_BIT] = a.batt_en;
        return r;
    endfunction

endpackage

// File: rtl/rtc_wdog_timer.sv
module rtc_wdog_timer
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick_i,
    input  logic              power_down_i,
    output wd_cfg_t           cfg_o,
    output logic              timeout_o,
    output logic              wd_pend_o,
    output logic              rst_req_o,
    output logic              zero_wr_o
);

    wd_cfg_t          cfg;
    logic             armed;
    logic [SUB_W-1:0] sub;
    logic [CNT_W-1:0] rem;
    logic             pend;
    logic             rst_req;

    logic wr_ok;
    logic load;
    logic zero_wr;
    logic unit_end;
    logic timeout;

    always_comb begin
        wr_ok    = wr_en & ~power_down_i;
        zero_wr  = wr_ok & (wdata == '0);
        load     = wr_ok & (wdata != '0);
        unit_end = armed & tick_i & (sub == last_sub(cfg.res));
        timeout  = unit_end & (rem <= CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || power_down_i) begin
            cfg     <= '0;
            armed   <= 1'b0;
            sub     <= '0;
            rem     <= '0;
            pend    <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= timeout & ~cfg.steer;
            if (load) begin
                cfg   <= wd_cfg_t'(wdata);
                armed <= 1'b1;
                sub   <= '0;
                rem   <= wdata[CNT_W-1:0];
            end else if (zero_wr) begin
                cfg   <= '0;
                armed <= 1'b0;
                sub   <= '0;
                rem   <= '0;
            end else if (armed && tick_i) begin
                if (unit_end) begin
                    sub <= '0;
                    if (timeout) begin
                        armed <= 1'b0;
                    end else begin
                        rem <= rem - CNT_W'(1);
                    end
                end else begin
                    sub <= sub + SUB_W'(1);
                end
            end
            if (zero_wr) begin
                pend <= 1'b0;
            end else if (timeout && cfg.steer) begin
                pend <= 1'b1;
            end
        end
    end

    assign cfg_o     = cfg;
    assign timeout_o = timeout;
    assign wd_pend_o = pend;
    assign rst_req_o = rst_req;
    assign zero_wr_o = zero_wr;

endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit
    import rtc_irq_pkg::*;
#(
    parameter int HOLD_CYC = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_flag_i,
    input  logic  alarm_hit_i,
    input  logic  wd_timeout_i,
    input  logic  wd_clear_i,
    output flag_t flags_o
);

    logic  rd_clr;
    flag_t flags;

    generate
        if (HOLD_CYC <= 1) begin : g_direct
            assign rd_clr = rd_flag_i;
        end else begin : g_hold
            localparam int HW = $clog2(HOLD_CYC);
            localparam logic [HW-1:0] HMAX = HW'(HOLD_CYC - 1);
            logic [HW-1:0] hold;
            always_ff @(posedge clk) begin
                if (rst) begin
                    hold <= '0;
                end else if (rd_flag_i) begin
                    if (hold != HMAX) begin
                        hold <= hold + HW'(1);
                    end
                end else begin
                    hold <= '0;
                end
            end
            assign rd_clr = rd_flag_i & (hold == HMAX);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            if (alarm_hit_i) begin
                flags.af <= 1'b1;
            end else if (rd_clr) begin
                flags.af <= 1'b0;
            end
            if (wd_clear_i) begin
                flags.wdf <= 1'b0;
            end else if (wd_timeout_i) begin
                flags.wdf <= 1'b1;
            end
        end
    end

    assign flags_o = flags;

endmodule

// File: rtl/rtc_pin_arb.sv
module rtc_pin_arb
    import rtc_irq_pkg::*;
(
    input  flag_t    flags_i,
    input  alm_cfg_t alm_i,
    input  logic     power_down_i,
    input  logic     wd_pend_i,
    input  logic     wd_steer_i,
    input  logic     freq_test_i,
    input  logic     ft_wave_i,
    output logic     alm_pend_o,
    output logic     irq_oe_n
);

    logic routed;
    logic any_pend;

    always_comb begin
        alm_pend_o = flags_i.af & alm_i.pin_en & (~power_down_i | alm_i.batt_en);
        routed     = wd_steer_i | alm_i.pin_en;
        any_pend   = alm_pend_o | wd_pend_i;
        if (any_pend) begin
            irq_oe_n = 1'b0;
        end else if (freq_test_i && !routed) begin
            irq_oe_n = ft_wave_i;
        end else begin
            irq_oe_n = 1'b1;
        end
    end

endmodule

// File: rtl/rtc_irq_wdog.sv
module rtc_irq_wdog
    import rtc_irq_pkg::*;
#(
    parameter int              ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] FLAG_ADDR  = 4'd0,
    parameter logic [ADDR_W-1:0] ALMEN_ADDR = 4'd6,
    parameter logic [ADDR_W-1:0] WDOG_ADDR  = 4'd7,
    parameter int              HOLD_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              tick_i,
    input  logic              alarm_hit_i,
    input  logic              freq_test_i,
    input  logic              ft_wave_i,
    input  logic              power_down_i,
    output logic              irq_oe_n,
    output logic              wd_rst_req_o
);

    alm_cfg_t alm;
    wd_cfg_t  wd_cfg;
    flag_t    flags;
    logic     wd_timeout;
    logic     wd_pend;
    logic     wd_zero_wr;
    logic     alm_pend;

    logic sel_flag;
    logic sel_alm;
    logic sel_wd;

    always_comb begin
        sel_flag = (bus_addr == FLAG_ADDR);
        sel_alm  = (bus_addr == ALMEN_ADDR);
        sel_wd   = (bus_addr == WDOG_ADDR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alm <= '0;
        end else if (bus_wr && sel_alm) begin
            alm.pin_en  <= bus_wdata[AEN_BIT];
            alm.batt_en <= bus_wdata[ABE_BIT];
        end
    end

    rtc_wdog_timer wd_u (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (bus_wr & sel_wd),
        .wdata        (bus_wdata),
        .tick_i       (tick_i),
        .power_down_i (power_down_i),
        .cfg_o        (wd_cfg),
        .timeout_o    (wd_timeout),
        .wd_pend_o    (wd_pend),
        .rst_req_o    (wd_rst_req_o),
        .zero_wr_o    (wd_zero_wr)
    );

    rtc_flag_unit #(
        .HOLD_CYC (HOLD_CYC)
    ) flag_u (
        .clk          (clk),
        .rst          (rst),
        .rd_flag_i    (bus_rd & sel_flag),
        .alarm_hit_i  (alarm_hit_i),
        .wd_timeout_i (wd_timeout),
        .wd_clear_i   (wd_zero_wr | power_down_i),
        .flags_o      (flags)
    );

    rtc_pin_arb arb_u (
        .flags_i      (flags),
        .alm_i        (alm),
        .power_down_i (power_down_i),
        .wd_pend_i    (wd_pend),
        .wd_steer_i   (wd_cfg.steer),
        .freq_test_i  (freq_test_i),
        .ft_wave_i    (ft_wave_i),
        .alm_pend_o   (alm_pend),
        .irq_oe_n     (irq_oe_n)
    );

    always_comb begin
        if (sel_flag) begin
            bus_rdata = pack_flags(flags);
        end else if (sel_alm) begin
            bus_rdata = pack_alm(alm);
        end else if (sel_wd) begin
            bus_rdata = wd_cfg;
        end else begin
            bus_rdata = '0;
        end
    end

endmodule

// File: rtl/rtc_irq_wdog_chk.sv
module rtc_irq_wdog_chk #(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] WDOG_ADDR = 4'd7
) (
    input logic              clk,
    input logic              rst,
    input logic              power_down_i,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              alarm_hit_i,
    input logic              freq_test_i,
    input logic              irq_oe_n,
    input logic              wd_rst_req_o,
    input logic [7:0]        wd_cfg,
    input logic [1:0]        flags,
    input logic              wd_pend,
    input logic              alm_pend
);

    assert_pd_clears_R10: assert property (@(posedge clk) disable iff (rst)
        power_down_i |=> (wd_cfg == 8'h00 && !wd_pend && !flags[1]));

    assert_rstreq_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        wd_rst_req_o |=> !wd_rst_req_o);

    assert_alarm_sets_R3: assert property (@(posedge clk) disable iff (rst)
        alarm_hit_i |=> flags[0]);

    assert_pend_pulls_R5: assert property (@(posedge clk) disable iff (rst)
        (alm_pend || wd_pend) |-> !irq_oe_n);

    assert_line_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !irq_oe_n |-> (alm_pend || wd_pend || freq_test_i));

    assert_zero_write_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == WDOG_ADDR && bus_wdata == 8'h00) |=> (!wd_pend && !flags[1]));

endmodule

bind rtc_irq_wdog rtc_irq_wdog_chk #(
    .ADDR_W    (ADDR_W),
    .WDOG_ADDR (WDOG_ADDR)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .power_down_i (power_down_i),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .alarm_hit_i  (alarm_hit_i),
    .freq_test_i  (freq_test_i),
    .irq_oe_n     (irq_oe_n),
    .wd_rst_req_o (wd_rst_req_o),
    .wd_cfg       (wd_cfg),
    .flags        (flags),
    .wd_pend      (wd_pend),
    .alm_pend     (alm_pend)
);

// File: tb/rtc_irq_wdog_tb_top.sv
module rtc_irq_wdog_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tick_i = 1'b0;
    logic       alarm_hit_i = 1'b0;
    logic       freq_test_i = 1'b0;
    logic       ft_wave_i = 1'b0;
    logic       power_down_i = 1'b0;
    logic       irq_oe_n;
    logic       wd_rst_req_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rtc_irq_wdog dut_i (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_rd       (bus_rd),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .tick_i       (tick_i),
        .alarm_hit_i  (alarm_hit_i),
        .freq_test_i  (freq_test_i),
        .ft_wave_i    (ft_wave_i),
        .power_down_i (power_down_i),
        .irq_oe_n     (irq_oe_n),
        .wd_rst_req_o (wd_rst_req_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int wd_ticks(input int cnt, input int res);
        return ((cnt == 0) ? 1 : cnt) * (1 << (2 * res));
    endfunction

    function automatic logic exp_line(input logic af, input logic pin_en, input logic batt,
                                      input logic pd, input logic wdp, input logic steer,
                                      input logic ft, input logic wave);
        logic ap;
        ap = af & pin_en & (~pd | batt);
        if (ap || wdp) return 1'b0;
        if (ft && !(pin_en || steer)) return wave;
        return 1'b1;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd1(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd2(input logic [3:0] a, input logic hit_late);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        alarm_hit_i = hit_late;
        @(negedge clk);
        bus_rd = 1'b0; alarm_hit_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
        end
    endtask

    task automatic hit();
        @(negedge clk);
        alarm_hit_i = 1'b1;
        @(negedge clk);
        alarm_hit_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd1(4'd0, d); check("R1 flags", d, 8'h00);
        rd1(4'd6, d); check("R1 almen", d, 8'h00);
        rd1(4'd7, d); check("R1 wdog", d, 8'h00);
        check("R1 line", irq_oe_n, 1'b1);
        check("R1 rstreq", wd_rst_req_o, 1'b0);

        // R2 register map
        wr(4'd6, 8'hFF); rd1(4'd6, d); check("R2 almen readback", d, 8'hC0);
        wr(4'd6, 8'h00);
        wr(4'd7, 8'hA5); rd1(4'd7, d); check("R2 wdog readback", d, 8'hA5);
        wr(4'd7, 8'h00);
        wr(4'd0, 8'hFF); rd1(4'd0, d); check("R2 flags read-only", d, 8'h00);
        rd1(4'd3, d); check("R2 unused addr", d, 8'h00);

        // R3 / R4 alarm flag
        hit(); rd1(4'd0, d); check("R3 alarm sets flag", d, 8'h40);
        rd1(4'd0, d); check("R4 single read keeps flag", d, 8'h40);
        rd2(4'd0, 1'b0); rd1(4'd0, d); check("R4 held read clears", d, 8'h00);
        hit(); rd2(4'd0, 1'b1); rd1(4'd0, d); check("R4 hit wins over clear", d, 8'h40);
        rd2(4'd0, 1'b0);

        // R5 alarm routing under supply loss
        wr(4'd6, 8'h80); hit();
        check("R5 alarm pulls line", irq_oe_n, 1'b0);
        @(negedge clk); power_down_i = 1'b1; #1
        check("R5 blocked on battery", irq_oe_n, 1'b1);
        wr(4'd6, 8'hC0); #1
        check("R5 battery enable", irq_oe_n, 1'b0);
        power_down_i = 1'b0;
        rd2(4'd0, 1'b0); #1 check("R5 released by clear", irq_oe_n, 1'b1);
        wr(4'd6, 8'h00);

        // R11 frequency test
        freq_test_i = 1'b1; ft_wave_i = 1'b0; #1
        check("R11 ft wave low", irq_oe_n, 1'b0);
        ft_wave_i = 1'b1; #1 check("R11 ft wave high", irq_oe_n, 1'b1);
        ft_wave_i = 1'b0;
        wr(4'd6, 8'h80); #1 check("R11 ft denied by alarm route", irq_oe_n, 1'b1);
        wr(4'd6, 8'h00);
        wr(4'd7, 8'h9F); #1 check("R11 ft denied by steer", irq_oe_n, 1'b1);
        wr(4'd7, 8'h00);
        freq_test_i = 1'b0;

        // R6 reload
        wr(4'd7, 8'h03); ticks(2); wr(4'd7, 8'h03); ticks(2);
        rd1(4'd0, d); check("R6 reload defers timeout", d, 8'h00);
        ticks(1); rd1(4'd0, d); check("R6 timeout after reload", d, 8'h80);
        // R9 zero write
        wr(4'd7, 8'h00); rd1(4'd0, d); check("R9 zero write clears flag", d, 8'h00);
        wr(4'd7, 8'h02); wr(4'd7, 8'h00); ticks(5);
        rd1(4'd0, d); check("R9 disabled no timeout", d, 8'h00);

        // R7 steered timeout
        wr(4'd7, 8'h81); ticks(1);
        check("R7 steered pulls line", irq_oe_n, 1'b0);
        rd2(4'd0, 1'b0); ticks(3);
        check("R7 stays after read", irq_oe_n, 1'b0);
        rd1(4'd0, d); check("R7 wdf set", d, 8'h80);
        wr(4'd7, 8'h00); #1 check("R7 zero write releases", irq_oe_n, 1'b1);

        // R8 reset request
        wr(4'd7, 8'h01); ticks(1);
        check("R8 rstreq high", wd_rst_req_o, 1'b1);
        check("R8 line untouched", irq_oe_n, 1'b1);
        @(negedge clk); check("R8 rstreq one cycle", wd_rst_req_o, 1'b0);
        wr(4'd7, 8'h00);

        // R10 power-down
        wr(4'd7, 8'h81);
        @(negedge clk); power_down_i = 1'b1;
        @(negedge clk); power_down_i = 1'b0;
        rd1(4'd7, d); check("R10 register cleared", d, 8'h00);
        ticks(3); check("R10 counter stopped", irq_oe_n, 1'b1);
        @(negedge clk); power_down_i = 1'b1;
        wr(4'd7, 8'h45); rd1(4'd7, d); check("R10 write ignored", d, 8'h00);
        @(negedge clk); power_down_i = 1'b0;
        rd1(4'd7, d); check("R10 still zero", d, 8'h00);

        // random watchdog configurations (R6, R7, R8)
        for (int it = 0; it < 12; it++) begin
            int cnt;
            int res;
            logic st;
            int n;
            cnt = $urandom_range(0, 6);
            res = $urandom_range(0, 3);
            st = 1'($urandom_range(0, 1));
            n = wd_ticks(cnt, res);
            wr(4'd7, {st, 2'(res), 5'(cnt)});
            ticks(n - 1);
            rd1(4'd0, d); check("R6 random early", d, 8'h00);
            ticks(1);
            check(st ? "R7 random line" : "R8 random rstreq",
                  st ? 32'(irq_oe_n) : 32'(wd_rst_req_o), st ? 32'd0 : 32'd1);
            rd1(4'd0, d); check("R6 random timeout flag", d, 8'h80);
            wr(4'd7, 8'h00);
        end

        // random alarm routing / line arbitration (R5, R11)
        for (int it = 0; it < 20; it++) begin
            logic pe;
            logic be;
            logic pd;
            logic ft;
            logic wv;
            logic af;
            pe = 1'($urandom_range(0, 1));
            be = 1'($urandom_range(0, 1));
            pd = 1'($urandom_range(0, 1));
            ft = 1'($urandom_range(0, 1));
            wv = 1'($urandom_range(0, 1));
            af = 1'($urandom_range(0, 1));
            wr(4'd6, {pe, be, 6'h00});
            if (af) hit();
            @(negedge clk);
            power_down_i = pd; freq_test_i = ft; ft_wave_i = wv;
            #1 check("R5 R11 random line", irq_oe_n,
                     exp_line(af, pe, be, pd, 1'b0, 1'b0, ft, wv));
            power_down_i = 1'b0;
            rd2(4'd0, 1'b0); #1
            check("R11 random after clear", irq_oe_n,
                  exp_line(1'b0, pe, be, 1'b0, 1'b0, 1'b0, ft, wv));
            freq_test_i = 1'b0;
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule